// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the sequencer of a boundary-scan test port, with the instruction register it owns. The serial test clock `tck` drives a sixteen-state machine. The mode-select input `tms` steers that machine on every rising edge of `tck`. An instruction path and a data path each walk a matching column of seven states: capture, shift, pause and update.

The instruction register has two stages. A shift stage captures a fixed pattern and then sits between `tdi` and `tdo` while it shifts. A latch stage takes the shifted value on a falling edge of `tck`, and that value becomes the current instruction. The all-ones instruction selects a built-in one-bit bypass register. Any other instruction routes the serial output of an external data register to `tdo`. Decoded strobes tell external data registers when to capture, shift and update.

Any state returns to the reset state after five rising edges with `tms` high. This makes the asynchronous `trst_n` input optional in use.

Top module: `scan_port_ctrl`

## Requirements
- R1: `state` uses this encoding: 0 reset, 1 idle, 2 select-data, 3 capture-data, 4 shift-data, 5 exit1-data, 6 pause-data, 7 exit2-data, 8 update-data, 9 select-instr, 10 capture-instr, 11 shift-instr, 12 exit1-instr, 13 pause-instr, 14 exit2-instr, 15 update-instr.
- R1 (continued): the state changes only on a rising edge of `tck`, following the standard `tms` mapping. Some examples:
  - reset stays in reset with `tms`=1 and goes to idle with `tms`=0.
  - idle goes to select-data with `tms`=1.
  - select-data goes to select-instr with `tms`=1.
  - select-instr goes to reset with `tms`=1.
  - update goes to select-data with `tms`=1 and to idle with `tms`=0.
- R2: From any of the 16 states, five rising edges with `tms`=1 reach reset (state 0).
- R3: `trst_n` low forces the following at once, without a clock edge: state 0, `instr` all ones, `tdo_en` 0.
- R4: In capture-instr, the rising edge loads the shift stage with the pattern 0…01 (bit 0 = 1, every other bit 0). In shift-instr, that pattern leaves on `tdo` bit 0 first.
- R5: In shift-instr, each rising edge moves the shift stage one place toward bit 0 and enters `tdi` at the top bit. This includes the edge that leaves shift-instr.
- R6: Pause and exit states keep the contents of the shift stage, whatever `tdi` does. Exit2 with `tms`=0 goes back to shift, so one value can be shifted in two parts.
- R7: `instr` takes the value of the shift stage on the falling edge of `tck` while in update-instr. It is unchanged just after the rising edge that enters update-instr.
- R8: On a falling edge of `tck` in reset, `instr` is loaded with all ones (the bypass code).
- R9: `tdo` and `tdo_en` change on falling edges of `tck`. `tdo_en` is 1 only in shift-instr or shift-data.
- R10: With `instr` all ones, shift-data goes through a one-bit bypass register. That register loads 0 in capture-data, so `tdo` shows 0 first and then each `tdi` bit one edge later. With any other `instr`, shift-data drives `tdo` from `dr_sdo`.
- R11: Each of the six strobes (capture, shift and update for the instruction and data paths) is high exactly while `state` is in the matching state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in |
| dr_sdo | input | 1 | Serial out of the selected external data register |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdo_en | output | 1 | Output enable for `tdo` |
| state | output | 4 | Current controller state (R1 encoding) |
| instr | output | IRW | Current latched instruction |
| ir_capture | output | 1 | High in capture-instr |
| ir_shift | output | 1 | High in shift-instr |
| ir_update | output | 1 | High in update-instr |
| dr_capture | output | 1 | High in capture-data |
| dr_shift | output | 1 | High in shift-data |
| dr_update | output | 1 | High in update-data |

## Verification
The bench first steers the machine into each of the sixteen states and then applies five `tms`-high edges. A bad transition in one state would leave the machine short of reset, or on the wrong state when the path ends.

Instruction scans check the following:
- The captured 0…01 pattern comes out low bit first.
- A scan split by a pause with a toggling `tdi` still latches the intended value. A design that shifted during pause would latch a corrupted instruction.
- The instruction is unchanged just after the rising edge into update. A design that latched on the rising edge would show the new code too early.

Bypass scans repeat after a `1` has been shifted in. This exposes a bypass register that fails to capture 0. Further scans check that any non-bypass code routes `dr_sdo` to `tdo`, and that both reset and `trst_n` restore the all-ones instruction.

// File: rtl/scan_port_ctrl.sv
`timescale 1ns/1ps
module scan_port_ctrl #(
  parameter int IRW = 4
) (
  input  logic           tck,
  input  logic           trst_n,
  input  logic           tms,
  input  logic           tdi,
  input  logic           dr_sdo,
  output logic           tdo,
  output logic           tdo_en,
  output logic [3:0]     state,
  output logic [IRW-1:0] instr,
  output logic           ir_capture,
  output logic           ir_shift,
  output logic           ir_update,
  output logic           dr_capture,
  output logic           dr_shift,
  output logic           dr_update
);
  localparam logic [3:0] S_RST  = 4'd0,  S_IDLE = 4'd1,  S_SELD = 4'd2,  S_CAPD = 4'd3;
  localparam logic [3:0] S_SHD  = 4'd4,  S_EX1D = 4'd5,  S_PAUD = 4'd6,  S_EX2D = 4'd7;
  localparam logic [3:0] S_UPDD = 4'd8,  S_SELI = 4'd9,  S_CAPI = 4'd10, S_SHI  = 4'd11;
  localparam logic [3:0] S_EX1I = 4'd12, S_PAUI = 4'd13, S_EX2I = 4'd14, S_UPDI = 4'd15;
  localparam logic [IRW-1:0] CAP_PAT  = {{(IRW-1){1'b0}}, 1'b1};
  localparam logic [IRW-1:0] BYPASS_C = {IRW{1'b1}};

  logic [3:0]     nxt;
  logic [IRW-1:0] ir_sh;
  logic           byp;
  logic           byp_sel;

  always_comb begin
    case (state)
      S_RST:   nxt = tms ? S_RST  : S_IDLE;
      S_IDLE:  nxt = tms ? S_SELD : S_IDLE;
      S_SELD:  nxt = tms ? S_SELI : S_CAPD;
      S_CAPD:  nxt = tms ? S_EX1D : S_SHD;
      S_SHD:   nxt = tms ? S_EX1D : S_SHD;
      S_EX1D:  nxt = tms ? S_UPDD : S_PAUD;
      S_PAUD:  nxt = tms ? S_EX2D : S_PAUD;
      S_EX2D:  nxt = tms ? S_UPDD : S_SHD;
      S_UPDD:  nxt = tms ? S_SELD : S_IDLE;
      S_SELI:  nxt = tms ? S_RST  : S_CAPI;
      S_CAPI:  nxt = tms ? S_EX1I : S_SHI;
      S_SHI:   nxt = tms ? S_EX1I : S_SHI;
      S_EX1I:  nxt = tms ? S_UPDI : S_PAUI;
      S_PAUI:  nxt = tms ? S_EX2I : S_PAUI;
      S_EX2I:  nxt = tms ? S_UPDI : S_SHI;
      default: nxt = tms ? S_SELD : S_IDLE;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) state <= S_RST;
    else         state <= nxt;

  assign ir_capture = (state == S_CAPI);
  assign ir_shift   = (state == S_SHI);
  assign ir_update  = (state == S_UPDI);
  assign dr_capture = (state == S_CAPD);
  assign dr_shift   = (state == S_SHD);
  assign dr_update  = (state == S_UPDD);
  assign byp_sel    = (instr == BYPASS_C);

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)         ir_sh <= CAP_PAT;
    else if (ir_capture) ir_sh <= CAP_PAT;
    else if (ir_shift)   ir_sh <= {tdi, ir_sh[IRW-1:1]};

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n)              instr <= BYPASS_C;
    else if (state == S_RST)  instr <= BYPASS_C;
    else if (ir_update)       instr <= ir_sh;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)                     byp <= 1'b0;
    else if (dr_capture && byp_sel)  byp <= 1'b0;
    else if (dr_shift && byp_sel)    byp <= tdi;

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= ir_shift | dr_shift;
      if (ir_shift)      tdo <= ir_sh[0];
      else if (dr_shift) tdo <= byp_sel ? byp : dr_sdo;
    end
endmodule

// File: rtl/scan_port_ctrl_chk.sv
`timescale 1ns/1ps
module scan_port_ctrl_chk #(
  parameter int IRW = 4
) (
  input logic           tck,
  input logic           trst_n,
  input logic           tms,
  input logic           tdo_en,
  input logic [3:0]     state,
  input logic [IRW-1:0] instr
);
  logic [2:0] ones_cnt;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)               ones_cnt <= 3'd0;
    else if (!tms)             ones_cnt <= 3'd0;
    else if (ones_cnt != 3'd7) ones_cnt <= ones_cnt + 3'd1;

  AST_FIVE_ONES:   assert property (@(posedge tck) disable iff (!trst_n) (ones_cnt >= 3'd5) |-> (state == 4'd0)); // R2
  AST_SELI_TO_RST: assert property (@(posedge tck) disable iff (!trst_n) (state == 4'd9 && tms) |=> (state == 4'd0)); // R1
  AST_IDLE_TO_SEL: assert property (@(posedge tck) disable iff (!trst_n) (state == 4'd1 && tms) |=> (state == 4'd2)); // R1
  AST_TDO_EN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n) tdo_en |-> (state == 4'd4 || state == 4'd11)); // R9
  AST_INSTR_CHANGE: assert property (@(posedge tck) disable iff (!trst_n) !$stable(instr) |-> (state == 4'd15 || state == 4'd0)); // R7
  AST_RESET_BYPASS: assert property (@(posedge tck) disable iff (!trst_n) (state == 4'd0) |-> (&instr)); // R8
endmodule

bind scan_port_ctrl scan_port_ctrl_chk #(.IRW(IRW)) u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .tdo_en(tdo_en), .state(state), .instr(instr)
);

// File: tb/scan_port_ctrl_test.sv
`timescale 1ns/1ps
module scan_port_ctrl_test;
  localparam int IRW = 4;
  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, dr_sdo = 1'b0;
  logic tdo, tdo_en, ir_capture, ir_shift, ir_update, dr_capture, dr_shift, dr_update;
  logic [3:0] state;
  logic [IRW-1:0] instr;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  scan_port_ctrl #(.IRW(IRW)) uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .dr_sdo(dr_sdo),
    .tdo(tdo), .tdo_en(tdo_en), .state(state), .instr(instr),
    .ir_capture(ir_capture), .ir_shift(ir_shift), .ir_update(ir_update),
    .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update)
  );

  always #4 tck = ~tck;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); #1;
  endtask

  task automatic at_fall;
    @(negedge tck); #1;
  endtask

  task automatic to_reset;
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
  endtask

  task automatic test_reset;
    check("R3 state", state, 0);
    check("R3 instr", instr, 4'hF);
    check("R3 tdo_en", tdo_en, 0);
    at_fall; trst_n = 1'b1;
    tick(1'b1, 1'b0);
    check("R1 reset holds with tms=1", state, 0);
  endtask

  task automatic test_walk;
    tick(1'b0, 1'b0); check("R1 reset->idle", state, 1);
    tick(1'b0, 1'b0); check("R1 idle holds", state, 1);
    tick(1'b1, 1'b0); check("R1 idle->select-data", state, 2);
    tick(1'b1, 1'b0); check("R1 select-data->select-instr", state, 9);
    tick(1'b1, 1'b0); check("R1 select-instr->reset", state, 0);
  endtask

  function automatic logic [11:0] path_of(input int s);
    case (s)
      1: return {4'd1, 8'b0};       2: return {4'd2, 8'b10};
      3: return {4'd3, 8'b010};     4: return {4'd4, 8'b0010};
      5: return {4'd4, 8'b1010};    6: return {4'd5, 8'b01010};
      7: return {4'd6, 8'b101010};  8: return {4'd5, 8'b11010};
      9: return {4'd3, 8'b110};     10: return {4'd4, 8'b0110};
      11: return {4'd5, 8'b00110};  12: return {4'd5, 8'b10110};
      13: return {4'd6, 8'b010110}; 14: return {4'd7, 8'b1010110};
      15: return {4'd6, 8'b110110}; default: return 12'd0;
    endcase
  endfunction

  task automatic test_five_ones;
    for (int s = 0; s < 16; s++) begin
      logic [11:0] p;
      p = path_of(s);
      to_reset;
      for (int k = 0; k < int'(p[11:8]); k++) tick(p[k], 1'b0);
      check($sformatf("R1 path to state %0d", s), state, s);
      to_reset;
      check($sformatf("R2 five ones from %0d", s), state, 0);
    end
  endtask

  task automatic load_ir(input logic [IRW-1:0] v);
    logic [IRW-1:0] cap;
    tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0);
    check("R11 ir_capture", {ir_capture, dr_capture}, 2'b10);
    tick(1'b0, 1'b0);
    check("R11 ir_shift", ir_shift, 1);
    for (int i = 0; i < IRW; i++) begin
      at_fall;
      cap[i] = tdo;
      check("R9 tdo_en in shift-instr", tdo_en, 1);
      tick(i == IRW-1, v[i]);
    end
    check("R4 captured pattern LSB first", cap, 4'b0001);
    at_fall;
    check("R9 tdo_en off in exit1", tdo_en, 0);
    tick(1'b1, 1'b0);
    check("R11 ir_update", ir_update, 1);
    check("R7 instr unchanged after rising edge", instr, 4'hF);
    at_fall;
    check("R5 R7 instr latched on falling edge", instr, v);
    tick(1'b0, 1'b0);
    check("R1 update->idle", state, 1);
  endtask

  task automatic test_ir_scan;
    to_reset; tick(1'b0, 1'b0);
    load_ir(4'b0010);
    to_reset; at_fall;
    check("R8 reset restores bypass", instr, 4'hF);
  endtask

  task automatic test_pause;
    to_reset; tick(1'b0, 1'b0);
    tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    tick(1'b0, 1'b1); tick(1'b1, 1'b0);
    check("R6 exit1-instr", state, 12);
    tick(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) tick(1'b0, ~tdi);
    check("R6 pause-instr", state, 13);
    at_fall;
    check("R9 tdo_en off in pause", tdo_en, 0);
    tick(1'b1, 1'b1); tick(1'b0, 1'b0);
    check("R6 exit2 back to shift", state, 11);
    tick(1'b0, 1'b0); tick(1'b1, 1'b1);
    tick(1'b1, 1'b0);
    at_fall;
    check("R6 split scan latched", instr, 4'b1001);
    tick(1'b1, 1'b0);
    check("R1 update-instr->select-data", state, 2);
  endtask

  task automatic test_bypass;
    logic [2:0] seen;
    to_reset; tick(1'b0, 1'b0);
    for (int pass = 0; pass < 2; pass++) begin
      tick(1'b1, 1'b0); tick(1'b0, 1'b0);
      check("R11 dr_capture", {dr_capture, ir_capture}, 2'b10);
      tick(1'b0, 1'b0);
      check("R11 dr_shift", {dr_shift, ir_shift}, 2'b10);
      at_fall; seen[0] = tdo;
      tick(1'b0, 1'b1); at_fall; seen[1] = tdo;
      tick(1'b0, 1'b0); at_fall; seen[2] = tdo;
      tick(1'b1, 1'b1);
      check($sformatf("R10 bypass stream pass %0d", pass), seen, 3'b010);
      tick(1'b1, 1'b0);
      check("R11 dr_update", {dr_update, ir_update}, 2'b10);
      tick(1'b0, 1'b0);
    end
  endtask

  task automatic test_ext_dr;
    to_reset; tick(1'b0, 1'b0);
    load_ir(4'b0110);
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    dr_sdo = 1'b1; at_fall;
    check("R10 external dr_sdo=1", tdo, 1);
    dr_sdo = 1'b0; tick(1'b0, 1'b1); at_fall;
    check("R10 external dr_sdo=0", tdo, 0);
    tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0);
    check("R10 idle with instr kept", instr, 4'b0110);
    #2 trst_n = 1'b0; #1;
    check("R3 async state", state, 0);
    check("R3 async instr", instr, 4'hF);
    at_fall; trst_n = 1'b1;
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #20;
    test_reset;
    test_walk;
    test_five_ones;
    test_ir_scan;
    test_pause;
    test_bypass;
    test_ext_dr;
    done = 1;
    finish_up;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      finish_up;
    end
  end
endmodule